// File: doc/BRIEF.md
# Frame Command Decoder with Paged Register Tables

The block takes a six-byte serial frame that an upstream receiver has already checked and turns it into one table operation. The low three bits of the first byte select one of eight command codes. The next two bytes are a page and an offset, which are folded into a 9-bit logical index. The two bytes after that form a 16-bit value. The final checksum byte is consumed upstream and never reaches this block, so only the first five bytes appear on the frame input.

Two 512-entry tables of 16-bit words hold the state. The primary table is written by the plain write command and by the quiet write command, and it is read by the read command. The secondary table is written only by its own command. The secondary table can be read by the logic outside the block that uses those values.

Commands that call for a reply load a held response record: a command code, an index and a value. A transmitter outside the block uses that record to build the reply frame, and it clears the record with an acknowledge. The clear, acknowledge-pending and unknown commands give one-cycle pulses instead of a reply.

Top module: `fcd_frame_decoder`

## Requirements
- R1: The command is frame bits [2:0], which are the low three bits of byte 0. Bits [7:3] of byte 0 have no effect on decoding.
- R2: The value is byte 3 (frame bits [31:24]) as the high byte and byte 4 (frame bits [39:32]) as the low byte. Byte 1 (bits [15:8]) is the page and byte 2 (bits [23:16]) is the offset.
- R3: The index is mapped as follows:
  - page 0 with an offset of 0x7F or below gives the offset itself;
  - page 1 gives 0x080 plus the offset;
  - page 2 with an offset of 0x7F or below gives 0x180 plus the offset;
  - every other page and offset gives 0x1FF.
- R4: Command 0 writes the value to the primary table at the index. One cycle after the strobe it raises the response request with code 0, the index and the value written.
- R5: Command 1 raises the response request one cycle after the strobe. The response carries code 1, the index and the primary table word at that index.
- R6: Command 4 writes the primary table and command 6 writes the secondary table. Neither command raises a response, and command 6 leaves the primary table unchanged.
- R7: Command 2 pulses clr_pulse_o and command 5 pulses ack_pulse_o. Each pulse is high for exactly the one cycle after the strobe, gives no response and changes no table.
- R8: Command 7 raises a response with code 7, the received index and the received value, and it changes no table.
- R9: Command 3 pulses unk_pulse_o for one cycle, gives no response and changes no table.
- R10: A raised response request stays high with stable fields until rsp_ack_i is seen at a clock edge, and it is low the cycle after. A new response replaces the held fields. When a new response and an acknowledge arrive in the same cycle, the new response wins.
- R11: After reset the response request and all pulses are low, and every word of both tables reads zero.
- R12: Frame contents have no effect while frame_vld_i is low. Each cycle with frame_vld_i high gives exactly one decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | Validated frame strobe, one cycle per frame |
| frame_i | input | 40 | Frame bytes 0..4; byte k is at bits [8k+7:8k] |
| rsp_ack_i | input | 1 | Transmitter has taken the held response |
| sec_rd_idx_i | input | 9 | Index for the secondary table read |
| rsp_req_o | output | 1 | Response record pending |
| rsp_cmd_o | output | 3 | Response command code |
| rsp_idx_o | output | 9 | Response logical index |
| rsp_val_o | output | 16 | Response value |
| sec_rd_data_o | output | 16 | Secondary table word at sec_rd_idx_i (combinational) |
| clr_pulse_o | output | 1 | Clear/abort command seen |
| ack_pulse_o | output | 1 | Acknowledge-pending command seen |
| unk_pulse_o | output | 1 | Unknown command seen |

## Verification
A fault in the index mapping shows on rsp_idx_o on the cycle after a command 7 strobe. A misrouted write stays hidden until a later command 1 read or a secondary port read returns the wrong word, so every write in the bench is followed by a read-back. A fault in the response holding register shows as a request that drops early or fields that shift while the request is pending, and sampling every cycle of the hold catches it at once. A fault in the command decode shows as a pulse or request in the wrong cycle, the cycle right after the strobe.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned IN_BYTES = 5;
  localparam int unsigned FRAME_W  = BYTE_W * IN_BYTES;
  localparam int unsigned DATA_W   = 2 * BYTE_W;
  localparam int unsigned IDX_W    = BYTE_W + 1;
  localparam int unsigned DEPTH    = 1 << IDX_W;
  localparam int unsigned CMD_W    = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_WR_REPLY = 3'd0,
    CMD_RD       = 3'd1,
    CMD_CLR      = 3'd2,
    CMD_RSV      = 3'd3,
    CMD_WR_QUIET = 3'd4,
    CMD_ACK      = 3'd5,
    CMD_WR_SEC   = 3'd6,
    CMD_RETX     = 3'd7
  } cmd_e;

  typedef struct packed {
    cmd_e              cmd;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] val;
  } rsp_t;
endpackage

// File: rtl/fcd_index_map.sv
module fcd_index_map #(
  parameter int unsigned BYTE_W = fcd_pkg::BYTE_W,
  localparam int unsigned IDX_W = BYTE_W + 1
) (
  input  logic [BYTE_W-1:0] page_i,
  input  logic [BYTE_W-1:0] off_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [IDX_W-1:0] HALF_BASE  = IDX_W'(1 << (BYTE_W - 1));
  localparam logic [IDX_W-1:0] UPPER_BASE = IDX_W'((1 << (BYTE_W - 1)) + (1 << BYTE_W));
  localparam logic [IDX_W-1:0] CATCH_IDX  = '1;

  logic in_low;
  assign in_low = ~off_i[BYTE_W-1];

  always_comb begin
    if (page_i == BYTE_W'(0) && in_low)      idx_o = IDX_W'(off_i);
    else if (page_i == BYTE_W'(1))           idx_o = HALF_BASE + IDX_W'(off_i);
    else if (page_i == BYTE_W'(2) && in_low) idx_o = UPPER_BASE + IDX_W'(off_i);
    else                                     idx_o = CATCH_IDX;
  end

  // R3: pages above 2 always land on the catch-all; page 1 stays in its band
  always_comb begin
    if (page_i > BYTE_W'(2)) a_r3_catch_all: assert (idx_o == CATCH_IDX);
    if (page_i == BYTE_W'(1))
      a_r3_page1_band: assert (idx_o >= HALF_BASE && idx_o < UPPER_BASE);
  end
endmodule

// File: rtl/fcd_reg_table.sv
module fcd_reg_table #(
  parameter int unsigned DEPTH  = fcd_pkg::DEPTH,
  parameter int unsigned DATA_W = fcd_pkg::DATA_W,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [AW-1:0]     ra_i,
  output logic [DATA_W-1:0] rd_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  assign rd_o = mem_q[ra_i];

  // R6: a word read back at the address just written holds the written data
  a_r6_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ra_i == wa_i) |=> (rd_o == $past(wd_i) || $past(ra_i) != ra_i || we_i));
endmodule

// File: rtl/fcd_rsp_hold.sv
module fcd_rsp_hold
  import fcd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  rsp_t load_data_i,
  input  logic ack_i,
  output logic req_o,
  output rsp_t data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      data_o <= '0;
    end else if (load_i) begin
      req_o  <= 1'b1;
      data_o <= load_data_i;
    end else if (ack_i) begin
      req_o  <= 1'b0;
    end
  end

  // R10: pending request survives until acknowledged, fields frozen meanwhile
  a_r10_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);
  a_r10_hold_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && !load_i) |=> $stable(data_o));
  a_r10_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !load_i) |=> !req_o);
endmodule

// File: rtl/fcd_frame_decoder.sv
module fcd_frame_decoder
  import fcd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_vld_i,
  input  logic [FRAME_W-1:0]  frame_i,
  input  logic                rsp_ack_i,
  input  logic [IDX_W-1:0]    sec_rd_idx_i,
  output logic                rsp_req_o,
  output logic [CMD_W-1:0]    rsp_cmd_o,
  output logic [IDX_W-1:0]    rsp_idx_o,
  output logic [DATA_W-1:0]   rsp_val_o,
  output logic [DATA_W-1:0]   sec_rd_data_o,
  output logic                clr_pulse_o,
  output logic                ack_pulse_o,
  output logic                unk_pulse_o
);
  localparam int unsigned N_EVT = 3;
  localparam cmd_e EVT_CMD [N_EVT] = '{CMD_CLR, CMD_ACK, CMD_RSV};

  cmd_e              cmd;
  logic [BYTE_W-1:0] page, off;
  logic [DATA_W-1:0] val;
  logic [IDX_W-1:0]  idx;
  logic              unused_hi;

  assign cmd       = cmd_e'(frame_i[CMD_W-1:0]);
  assign unused_hi = ^frame_i[BYTE_W-1:CMD_W];
  assign page      = frame_i[2*BYTE_W-1 : BYTE_W];
  assign off       = frame_i[3*BYTE_W-1 : 2*BYTE_W];
  assign val       = {frame_i[4*BYTE_W-1 : 3*BYTE_W], frame_i[5*BYTE_W-1 : 4*BYTE_W]};

  fcd_index_map #(.BYTE_W(BYTE_W)) u_map (
    .page_i (page),
    .off_i  (off),
    .idx_o  (idx)
  );

  logic              pri_we, sec_we;
  logic [DATA_W-1:0] pri_rd;

  assign pri_we = frame_vld_i && (cmd == CMD_WR_REPLY || cmd == CMD_WR_QUIET);
  assign sec_we = frame_vld_i && (cmd == CMD_WR_SEC);

  fcd_reg_table #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_pri (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (pri_we),
    .wa_i   (idx),
    .wd_i   (val),
    .ra_i   (idx),
    .rd_o   (pri_rd)
  );

  fcd_reg_table #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_sec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sec_we),
    .wa_i   (idx),
    .wd_i   (val),
    .ra_i   (sec_rd_idx_i),
    .rd_o   (sec_rd_data_o)
  );

  logic rsp_load;
  rsp_t rsp_next, rsp_q;

  assign rsp_load = frame_vld_i &&
                    (cmd == CMD_WR_REPLY || cmd == CMD_RD || cmd == CMD_RETX);

  always_comb begin
    rsp_next.cmd = cmd;
    rsp_next.idx = idx;
    rsp_next.val = (cmd == CMD_RD) ? pri_rd : val;
  end

  fcd_rsp_hold u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (rsp_load),
    .load_data_i (rsp_next),
    .ack_i       (rsp_ack_i),
    .req_o       (rsp_req_o),
    .data_o      (rsp_q)
  );

  assign rsp_cmd_o = rsp_q.cmd;
  assign rsp_idx_o = rsp_q.idx;
  assign rsp_val_o = rsp_q.val;

  logic [N_EVT-1:0] evt_q;

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_q[g] <= 1'b0;
      else         evt_q[g] <= frame_vld_i && (cmd == EVT_CMD[g]);
    end
  end

  assign clr_pulse_o = evt_q[0];
  assign ack_pulse_o = evt_q[1];
  assign unk_pulse_o = evt_q[2];

  // R7, R9: at most one event pulse, each traced to a strobe one cycle earlier
  a_r7_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clr_pulse_o, ack_pulse_o, unk_pulse_o}));
  a_r9_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pulse_o || ack_pulse_o || unk_pulse_o) |-> $past(frame_vld_i));
  // R12: a response never appears without a strobe
  a_r12_rsp_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_req_o) |-> $past(frame_vld_i));
  // R4: a pulse and a response never come from the same frame
  a_r4_no_pulse_with_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pulse_o || ack_pulse_o || unk_pulse_o) |-> !$rose(rsp_req_o));
endmodule

// File: tb/sim_fcd_frame_decoder.sv
module sim_fcd_frame_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_vld = 1'b0;
  logic [39:0] frame = '0;
  logic        rsp_ack = 1'b0;
  logic [8:0]  sec_idx = '0;
  logic        rsp_req, clr_p, ack_p, unk_p;
  logic [2:0]  rsp_cmd;
  logic [8:0]  rsp_idx;
  logic [15:0] rsp_val, sec_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fcd_frame_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_vld_i(frame_vld), .frame_i(frame),
    .rsp_ack_i(rsp_ack), .sec_rd_idx_i(sec_idx), .rsp_req_o(rsp_req),
    .rsp_cmd_o(rsp_cmd), .rsp_idx_o(rsp_idx), .rsp_val_o(rsp_val),
    .sec_rd_data_o(sec_data), .clr_pulse_o(clr_p), .ack_pulse_o(ack_p),
    .unk_pulse_o(unk_p)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_idx(logic [7:0] pg, logic [7:0] of);
    if (pg == 0 && of < 8'h80) return {1'b0, of};
    if (pg == 1) return 9'h080 + {1'b0, of};
    if (pg == 2 && of < 8'h80) return 9'h180 + {1'b0, of};
    return 9'h1FF;
  endfunction

  // drive one frame; returns at the negedge after the decoding edge
  task automatic send(logic [7:0] b0, logic [7:0] pg, logic [7:0] of, logic [15:0] v);
    @(negedge clk);
    frame_vld = 1'b1;
    frame = {v[7:0], v[15:8], of, pg, b0};
    @(negedge clk);
    frame_vld = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
  endtask

  task automatic read_pri(string tag, logic [7:0] pg, logic [7:0] of, logic [15:0] exp);
    send(8'h01, pg, of, 16'h0);
    chk({tag, " read req"}, rsp_req, 1);
    chk({tag, " read val"}, rsp_val, exp);
    do_ack();
  endtask

  task automatic t_reset();
    chk("R11 req", rsp_req, 0);
    chk("R11 pulses", {clr_p, ack_p, unk_p}, 0);
    sec_idx = 9'h005; #1;
    chk("R11 sec 005", sec_data, 0);
    sec_idx = 9'h1FF; #1;
    chk("R11 sec 1ff", sec_data, 0);
    read_pri("R11 pri", 8'h00, 8'h11, 16'h0);
  endtask

  task automatic t_write_read();
    send(8'h00, 8'h00, 8'h10, 16'h1234);
    chk("R4 req", rsp_req, 1);
    chk("R4 cmd", rsp_cmd, 0);
    chk("R4 idx", rsp_idx, 9'h010);
    chk("R2 R4 val", rsp_val, 16'h1234);
    do_ack();
    chk("R10 ack clears", rsp_req, 0);
    send(8'h01, 8'h00, 8'h10, 16'hFFFF);
    chk("R5 cmd", rsp_cmd, 1);
    chk("R5 idx", rsp_idx, 9'h010);
    chk("R5 val", rsp_val, 16'h1234);
    do_ack();
  endtask

  task automatic t_index_map();
    logic [7:0] pg [9] = '{8'h00, 8'h00, 8'h01, 8'h01, 8'h02, 8'h02, 8'h02, 8'h03, 8'hFF};
    logic [7:0] of [9] = '{8'h7F, 8'h80, 8'h00, 8'hFF, 8'h00, 8'h7E, 8'h80, 8'h00, 8'h05};
    for (int i = 0; i < 9; i++) begin
      send(8'h07, pg[i], of[i], 16'hC000 + 16'(i));
      chk("R3 idx", rsp_idx, exp_idx(pg[i], of[i]));
      chk("R8 cmd", rsp_cmd, 7);
      chk("R8 val", rsp_val, 16'hC000 + 16'(i));
      do_ack();
    end
  endtask

  task automatic t_cmd_mask();
    send(8'hF8, 8'h01, 8'h22, 16'hBEEF);
    chk("R1 masked cmd0", rsp_cmd, 0);
    chk("R1 R3 idx", rsp_idx, 9'h0A2);
    do_ack();
    send(8'h09, 8'h01, 8'h22, 16'h0);
    chk("R1 masked cmd1", rsp_cmd, 1);
    chk("R1 read", rsp_val, 16'hBEEF);
    do_ack();
    // R12: frame present but no strobe
    @(negedge clk);
    frame = {8'h11, 8'h11, 8'h22, 8'h01, 8'h00};
    repeat (3) @(negedge clk);
    chk("R12 no req", rsp_req, 0);
    read_pri("R12 untouched", 8'h01, 8'h22, 16'hBEEF);
  endtask

  task automatic t_no_reply();
    send(8'h04, 8'h00, 8'h30, 16'h5555);
    chk("R6 quiet no req", rsp_req, 0);
    read_pri("R6 quiet wrote", 8'h00, 8'h30, 16'h5555);
    send(8'h06, 8'h02, 8'h01, 16'h6666);
    chk("R6 sec no req", rsp_req, 0);
    sec_idx = 9'h181; #1;
    chk("R6 sec data", sec_data, 16'h6666);
    read_pri("R6 pri untouched", 8'h02, 8'h01, 16'h0);
  endtask

  task automatic t_pulses();
    send(8'h02, 8'h00, 8'h10, 16'h9999);
    chk("R7 clr", {clr_p, ack_p, unk_p}, 3'b100);
    chk("R7 clr no req", rsp_req, 0);
    @(negedge clk);
    chk("R7 clr one cycle", clr_p, 0);
    send(8'h05, 8'h00, 8'h10, 16'h8888);
    chk("R7 ack", {clr_p, ack_p, unk_p}, 3'b010);
    chk("R7 ack no req", rsp_req, 0);
    @(negedge clk);
    chk("R7 ack one cycle", ack_p, 0);
    read_pri("R7 table kept", 8'h00, 8'h10, 16'h1234);
  endtask

  task automatic t_unknown();
    send(8'h03, 8'h00, 8'h10, 16'hAAAA);
    chk("R9 unk", {clr_p, ack_p, unk_p}, 3'b001);
    chk("R9 no req", rsp_req, 0);
    send(8'h07, 8'h00, 8'h10, 16'hDEAD);
    chk("R8 retx val", rsp_val, 16'hDEAD);
    do_ack();
    read_pri("R8 R9 table kept", 8'h00, 8'h10, 16'h1234);
    sec_idx = 9'h010; #1;
    chk("R9 sec kept", sec_data, 0);
  endtask

  task automatic t_hold();
    send(8'h00, 8'h00, 8'h40, 16'h0001);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 held req", rsp_req, 1);
      chk("R10 held val", rsp_val, 16'h0001);
    end
    send(8'h07, 8'h00, 8'h41, 16'h0002);
    chk("R10 replace cmd", rsp_cmd, 7);
    chk("R10 replace idx", rsp_idx, 9'h041);
    @(negedge clk);
    frame_vld = 1'b1;
    rsp_ack = 1'b1;
    frame = {8'h00, 8'h00, 8'h40, 8'h00, 8'h01};
    @(negedge clk);
    frame_vld = 1'b0;
    rsp_ack = 1'b0;
    chk("R10 load beats ack", rsp_req, 1);
    chk("R10 new cmd", rsp_cmd, 1);
    chk("R10 new val", rsp_val, 16'h0001);
    do_ack();
    chk("R10 final clear", rsp_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_index_map();
    t_cmd_mask();
    t_no_reply();
    t_pulses();
    t_unknown();
    t_hold();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule